// File: doc/BRIEF.md
# Cascaded Priority Interrupt Controller Pair

This block puts two eight-input priority interrupt controllers behind one processor interrupt line. The second controller (the slave) is chained into input 2 of the first (the master), which gives fifteen usable request channels. Each controller catches rising edges on its request inputs, holds them as pending, filters them through a mask, and compares the best pending request with the requests already in service. It asserts an interrupt only when the new request has strictly higher priority than every request in service.

The processor answers with two acknowledge strobes. The first strobe moves the winning request into service. The second strobe returns an 8-bit vector: the controller's programmable base in bits 7:3 and the channel number in bits 2:0. Each controller has two byte registers on a shared I/O port, at 0x020/0x021 for the master and 0x0A0/0x0A1 for the slave. Software uses them to set masks, select a read view, load vector bases and issue end-of-interrupt commands.

The timer channel 0 output and the real-time clock request are wired in internally. A one-cycle activity strobe tells a power manager each time a real request is acknowledged.

Top module: `pic_cascade_pair`

## Requirements
- R1: The master answers at I/O addresses 0x020 (even) and 0x021 (odd), and the slave at 0x0A0 and 0x0A1. A read of any other address returns 0x00. A write to an odd address sets that controller's mask register (bit n = 1 masks input n), and a read of an odd address returns the mask. After reset both masks are 0xFF, every pending and in-service bit is 0, and the CPU interrupt is low.
- R2: A request becomes pending on a 0-to-1 transition of its input. A request line held high after it has been acknowledged does not request again until it falls and rises.
- R3: A masked pending request does not raise the CPU interrupt but stays pending. It raises the interrupt once its mask bit is cleared.
- R4: Priority is fixed: a lower input number wins over a higher one on the same controller.
- R5: Fully nested: a request raises the interrupt only if its priority is strictly higher than every in-service request on that controller. A higher-priority request preempts the one in service.
- R6: On the first CPU acknowledge strobe, the winning request leaves the pending register and enters the in-service register. The second strobe makes `vec_data` equal to base[7:3] | channel, with `vec_valid` high for exactly the cycle after that strobe.
- R7: A slave request reaches the CPU through master input 2, at the priority of master input 2. When master input 2 wins, the slave supplies the vector from its own base, and both the master's bit 2 and the slave's bit become in-service.
- R8: An even-address write of 0x20 is a non-specific end-of-interrupt. It clears only the highest-priority in-service bit of that controller. Master bit 2 stays in service until the master itself receives an end-of-interrupt.
- R9: Master input 0 is the timer input and slave input 0 is the real-time clock input. Lines `ext_irq` 0, 2, 8 and 13 have no effect, and slave input 5 (system IRQ13) never becomes pending or in service.
- R10: An even-address write with bit 4 set clears that controller's pending and in-service bits. The next odd-address write then loads the vector base from data bits 7:3 and leaves the mask unchanged. Reset bases are 0x08 for the master and 0x70 for the slave.
- R11: An even-address write of 0x0A makes later even-address reads return the pending register, and 0x0B makes them return the in-service register. After reset, even-address reads return the pending register.
- R12: `pm_activity` pulses high for one cycle after each first acknowledge strobe that finds a real request.
- R13: An acknowledge with no winning request returns the master base with channel 7. It changes no in-service bit and does not pulse `pm_activity`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | ADDR_W | I/O register address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for the addressed register (combinational) |
| ext_irq | input | 16 | External request lines indexed by system IRQ number |
| timer0_irq | input | 1 | Timer channel 0 output |
| rtc_irq | input | 1 | Real-time clock request |
| cpu_int | output | 1 | Interrupt request to the processor |
| cpu_inta | input | 1 | Acknowledge strobe; two strobes form one acknowledge |
| vec_data | output | 8 | Interrupt vector |
| vec_valid | output | 1 | Vector valid, one cycle |
| pm_activity | output | 1 | Activity pulse to the power manager |

## Verification
The bench targets nesting. It checks that a lower-priority request stays silent while a higher one is in service, and that a higher one still preempts; a design that compared with "less or equal", or ignored the in-service register, would raise `cpu_int` at the wrong times. For the cascade it checks that a slave end-of-interrupt leaves master bit 2 set; a design that cleared both together would let lower master inputs in early. It also checks that a held request line is not taken twice, that lines 0, 2, 8 and 13 stay silent, that an acknowledge with nothing pending returns channel 7 without an activity pulse, and that the init sequence loads the base rather than the mask.

// File: rtl/pic_pkg.sv
// Shared constants and types for the cascaded interrupt controller pair.
// Assumes byte-wide controllers (eight inputs each).
package pic_pkg;
    localparam int CH_N  = 8;
    localparam int CH_W  = $clog2(CH_N);
    localparam int CASC_CH = 2;                    // master input carrying the slave
    localparam logic [4:0] EOI_OP = 5'b00100;      // data[7:3] of a non-specific EOI

    typedef enum logic { VIEW_PEND = 1'b0, VIEW_SERV = 1'b1 } view_e;
endpackage

// File: rtl/pic_prio.sv
// Fixed-priority finder: returns the lowest set index of a vector.
// Assumes N is a power of two; idx is 0 when nothing is set.
module pic_prio #(
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    // Scan from the top down so the lowest set bit wins.
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                any_o = 1'b1;
                idx_o = IW'(i);
            end
        end
    end
endmodule

// File: rtl/pic_unit.sv
// One priority interrupt controller. It catches request edges, holds
// pending / in-service / mask registers, resolves fully nested fixed
// priority, and decodes commands written through its two-register window.
// Assumes sel_i is already the address decode and that writes last one cycle.
module pic_unit
    import pic_pkg::*;
#(
    parameter logic [7:0] BASE_RST = 8'h08
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CH_N-1:0] req_i,
    input  logic            sel_i,
    input  logic            a0_i,
    input  logic            wr_i,
    input  logic [7:0]      wdata_i,
    output logic [7:0]      rdata_o,
    input  logic            ack_i,
    output logic            int_o,
    output logic [CH_W-1:0] ack_ch_o,
    output logic [4:0]      vbase_o,
    output logic [CH_N-1:0] isr_o
);
    logic [CH_N-1:0] req_q, irr_q, isr_q, imr_q;
    logic [4:0]      base_q;
    logic            arm_q;
    view_e           view_q;

    logic [CH_N-1:0] pend, rise, take, done;
    logic            p_any, s_any;
    logic [CH_W-1:0] p_idx, s_idx;
    logic            wr_hit, init_cmd, view_cmd, eoi_cmd;

    assign pend = irr_q & ~imr_q;
    assign rise = req_i & ~req_q;

    pic_prio #(.N(CH_N)) u_pend_prio (.vec_i(pend),  .any_o(p_any), .idx_o(p_idx));
    pic_prio #(.N(CH_N)) u_serv_prio (.vec_i(isr_q), .any_o(s_any), .idx_o(s_idx));

    // Win only when strictly above every request in service.
    assign int_o    = p_any && (!s_any || (p_idx < s_idx));
    assign ack_ch_o = int_o ? p_idx : CH_W'(CH_N - 1);

    // Command decode for the even (command) and odd (data) registers.
    assign wr_hit   = sel_i && wr_i;
    assign init_cmd = wr_hit && !a0_i && wdata_i[4];
    assign view_cmd = wr_hit && !a0_i && !wdata_i[4] && wdata_i[3] && wdata_i[1];
    assign eoi_cmd  = wr_hit && !a0_i && (wdata_i[7:3] == EOI_OP) && (wdata_i[2:0] == 3'b000);

    assign take = (ack_i && int_o) ? (CH_N'(1) << p_idx) : '0;
    assign done = (eoi_cmd && s_any) ? (CH_N'(1) << s_idx) : '0;

    // Request edge capture and pending register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
            irr_q <= '0;
        end else begin
            req_q <= req_i;
            irr_q <= init_cmd ? '0 : ((irr_q & ~take) | rise);
        end
    end

    // In-service register: set on acknowledge, cleared by EOI or init.
    always_ff @(posedge clk) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= init_cmd ? '0 : ((isr_q | take) & ~done);
    end

    // Mask, vector base, init arming and read view.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imr_q  <= '1;
            base_q <= BASE_RST[7:3];
            arm_q  <= 1'b0;
            view_q <= VIEW_PEND;
        end else begin
            if (init_cmd) arm_q <= 1'b1;
            if (view_cmd) view_q <= view_e'(wdata_i[0]);
            if (wr_hit && a0_i) begin
                if (arm_q) begin
                    base_q <= wdata_i[7:3];
                    arm_q  <= 1'b0;
                end else begin
                    imr_q <= wdata_i;
                end
            end
        end
    end

    // Read mux for the two registers.
    always_comb begin
        if (a0_i)                    rdata_o = imr_q;
        else if (view_q == VIEW_SERV) rdata_o = isr_q;
        else                         rdata_o = irr_q;
    end

    assign vbase_o = base_q;
    assign isr_o   = isr_q;

    // R6
    take_into_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && int_o && !wr_hit) |=> isr_q[$past(ack_ch_o)]);
    // R5
    nest_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_o |-> !isr_q[ack_ch_o]);
    // R8
    isr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_i && !wr_hit) |=> $stable(isr_q));
    // R2
    irr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_i && !wr_hit) |=> ((irr_q & $past(irr_q)) == $past(irr_q)));
endmodule

// File: rtl/pic_ack_seq.sv
// Two-strobe acknowledge sequencer. The first strobe acknowledges the master,
// and the slave as well when master input 2 wins. It latches the vector,
// which the second strobe presents. Assumes strobes come in pairs.
module pic_ack_seq
    import pic_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            inta_i,
    input  logic            m_int_i,
    input  logic [CH_W-1:0] m_ch_i,
    input  logic [4:0]      m_base_i,
    input  logic [CH_W-1:0] s_ch_i,
    input  logic [4:0]      s_base_i,
    output logic            m_ack_o,
    output logic            s_ack_o,
    output logic [7:0]      vec_o,
    output logic            vec_valid_o,
    output logic            pm_o
);
    logic       phase_q;
    logic [7:0] hold_q;

    assign m_ack_o = inta_i && !phase_q;
    assign s_ack_o = m_ack_o && m_int_i && (m_ch_i == CH_W'(CASC_CH));

    // Phase tracking, vector capture and activity strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= 1'b0;
            hold_q      <= '0;
            vec_o       <= '0;
            vec_valid_o <= 1'b0;
            pm_o        <= 1'b0;
        end else begin
            pm_o        <= m_ack_o && m_int_i;
            vec_valid_o <= 1'b0;
            if (m_ack_o) begin
                phase_q <= 1'b1;
                hold_q  <= s_ack_o ? {s_base_i, s_ch_i} : {m_base_i, m_ch_i};
            end else if (inta_i) begin
                phase_q     <= 1'b0;
                vec_o       <= hold_q;
                vec_valid_o <= 1'b1;
            end
        end
    end

    // R6
    vec_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |=> !vec_valid_o);
    // R6
    vec_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> $past(inta_i));
    // R12
    pm_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pm_o |=> !pm_o);
endmodule

// File: rtl/pic_cascade_pair.sv
// Master/slave interrupt controller pair with fixed internal wiring: slave
// into master input 2, timer into master input 0, real-time clock into slave
// input 0, system IRQ13 tied off. Assumes one register access per cycle.
module pic_cascade_pair
    import pic_pkg::*;
#(
    parameter int                ADDR_W  = 10,
    parameter logic [ADDR_W-1:0] M_ADDR  = 'h020,
    parameter logic [ADDR_W-1:0] S_ADDR  = 'h0A0,
    parameter logic [7:0]        M_VBASE = 8'h08,
    parameter logic [7:0]        S_VBASE = 8'h70
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic [15:0]       ext_irq,
    input  logic              timer0_irq,
    input  logic              rtc_irq,
    output logic              cpu_int,
    input  logic              cpu_inta,
    output logic [7:0]        vec_data,
    output logic              vec_valid,
    output logic              pm_activity
);
    logic            m_sel, s_sel;
    logic [CH_N-1:0] m_req, s_req, m_isr, s_isr;
    logic [7:0]      m_rd, s_rd;
    logic            m_int, s_int, m_ack, s_ack;
    logic [CH_W-1:0] m_ch, s_ch;
    logic [4:0]      m_base, s_base;
    logic            unused_ext;

    assign m_sel = (io_addr[ADDR_W-1:1] == M_ADDR[ADDR_W-1:1]);
    assign s_sel = (io_addr[ADDR_W-1:1] == S_ADDR[ADDR_W-1:1]);

    // Fixed input wiring of both controllers.
    assign m_req = {ext_irq[7:3], s_int, ext_irq[1], timer0_irq};
    assign s_req = {ext_irq[15:14], 1'b0, ext_irq[12:9], rtc_irq};
    assign unused_ext = ^{ext_irq[0], ext_irq[2], ext_irq[8], ext_irq[13]};

    pic_unit #(.BASE_RST(M_VBASE)) u_master (
        .clk(clk), .rst_n(rst_n), .req_i(m_req), .sel_i(m_sel), .a0_i(io_addr[0]),
        .wr_i(io_wr), .wdata_i(io_wdata), .rdata_o(m_rd), .ack_i(m_ack),
        .int_o(m_int), .ack_ch_o(m_ch), .vbase_o(m_base), .isr_o(m_isr));

    pic_unit #(.BASE_RST(S_VBASE)) u_slave (
        .clk(clk), .rst_n(rst_n), .req_i(s_req), .sel_i(s_sel), .a0_i(io_addr[0]),
        .wr_i(io_wr), .wdata_i(io_wdata), .rdata_o(s_rd), .ack_i(s_ack),
        .int_o(s_int), .ack_ch_o(s_ch), .vbase_o(s_base), .isr_o(s_isr));

    pic_ack_seq u_ack (
        .clk(clk), .rst_n(rst_n), .inta_i(cpu_inta), .m_int_i(m_int), .m_ch_i(m_ch),
        .m_base_i(m_base), .s_ch_i(s_ch), .s_base_i(s_base), .m_ack_o(m_ack),
        .s_ack_o(s_ack), .vec_o(vec_data), .vec_valid_o(vec_valid), .pm_o(pm_activity));

    // Read data select across the two register windows.
    always_comb begin
        if (m_sel)      io_rdata = m_rd;
        else if (s_sel) io_rdata = s_rd;
        else            io_rdata = 8'h00;
    end

    assign cpu_int = m_int;

    // R9
    no_irq13_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_isr[5]);
    // R7
    slave_under_casc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_isr != '0) |-> (m_isr[CASC_CH] || $past(io_wr)));
endmodule

// File: tb/test_pic_cascade_pair.sv
module test_pic_cascade_pair;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  io_addr = '0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [15:0] ext_irq = '0;
    logic        timer0_irq = 1'b0;
    logic        rtc_irq = 1'b0;
    logic        cpu_int;
    logic        cpu_inta = 1'b0;
    logic [7:0]  vec_data;
    logic        vec_valid;
    logic        pm_activity;

    int checks = 0;
    int errors = 0;
    int pm_cnt = 0;
    int pm_exp = 0;
    logic [7:0] exp_q[$];
    logic [7:0] rd;

    always #(CLK_P/2) clk = ~clk;

    pic_cascade_pair i_pic_cascade_pair (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .ext_irq(ext_irq), .timer0_irq(timer0_irq), .rtc_irq(rtc_irq),
        .cpu_int(cpu_int), .cpu_inta(cpu_inta), .vec_data(vec_data), .vec_valid(vec_valid),
        .pm_activity(pm_activity));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic io_write(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk); io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [9:0] a, output logic [7:0] d);
        @(negedge clk); io_addr = a; #1 d = io_rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_ext(input int n);
        @(negedge clk); ext_irq[n] = 1'b1;
        @(negedge clk); ext_irq[n] = 1'b0;
        settle();
    endtask

    // Driver: queue the expected vector, then run the two acknowledge strobes.
    task automatic do_ack(input logic [7:0] exp_vec, input bit real_req);
        exp_q.push_back(exp_vec);
        if (real_req) pm_exp++;
        @(negedge clk); cpu_inta = 1'b1;
        @(negedge clk); cpu_inta = 1'b0;
        @(negedge clk); cpu_inta = 1'b1;
        @(negedge clk); cpu_inta = 1'b0;
        @(negedge clk);
    endtask

    task automatic chk_int(input string req, input logic exp);
        @(negedge clk);
        chk(req, {7'b0, cpu_int}, {7'b0, exp});
    endtask

    // Monitor: compare each produced vector with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && vec_valid) begin
            if (exp_q.size() == 0) chk("R6 unexpected vector", vec_data, 8'hxx);
            else chk("R6 vector", vec_data, exp_q.pop_front());
        end
        if (rst_n && pm_activity) pm_cnt++;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state and decode
        chk_int("R1 int after reset", 1'b0);
        io_read(10'h021, rd); chk("R1 master mask reset", rd, 8'hFF);
        io_read(10'h0A1, rd); chk("R1 slave mask reset", rd, 8'hFF);
        io_read(10'h020, rd); chk("R1 pending reset (R11 default view)", rd, 8'h00);
        io_read(10'h022, rd); chk("R1 unmapped read", rd, 8'h00);
        io_write(10'h021, 8'h00);
        io_write(10'h0A1, 8'h00);
        io_read(10'h021, rd); chk("R1 mask write", rd, 8'h00);

        // R2 edge capture with line held high
        @(negedge clk); ext_irq[3] = 1'b1;
        settle();
        chk_int("R2 edge raises int", 1'b1);
        io_read(10'h020, rd); chk("R2 pending view", rd, 8'h08);
        do_ack(8'h0B, 1);
        chk_int("R2 held line no rerequest", 1'b0);
        io_write(10'h020, 8'h0B);
        io_read(10'h020, rd); chk("R11 in-service view", rd, 8'h08);
        io_write(10'h020, 8'h20);
        io_read(10'h020, rd); chk("R8 EOI clears", rd, 8'h00);
        chk_int("R2 still held no int", 1'b0);
        @(negedge clk); ext_irq[3] = 1'b0;
        chk("R12 one pulse per ack", 8'(pm_cnt), 8'(pm_exp));

        // R3 masking
        io_write(10'h021, 8'h10);
        pulse_ext(4);
        chk_int("R3 masked no int", 1'b0);
        io_write(10'h020, 8'h0A);
        io_read(10'h020, rd); chk("R3 masked stays pending", rd, 8'h10);
        io_write(10'h021, 8'h00);
        chk_int("R3 unmask raises int", 1'b1);
        do_ack(8'h0C, 1);
        io_write(10'h020, 8'h20);

        // R4 simultaneous requests, R5 nesting blocks lower
        @(negedge clk); ext_irq[3] = 1'b1; ext_irq[5] = 1'b1;
        @(negedge clk); ext_irq[3] = 1'b0; ext_irq[5] = 1'b0;
        settle();
        do_ack(8'h0B, 1);
        chk_int("R5 lower blocked while higher in service", 1'b0);
        io_write(10'h020, 8'h20);
        chk_int("R5 lower released after EOI", 1'b1);
        do_ack(8'h0D, 1);
        io_write(10'h020, 8'h20);

        // R5 preemption, R8 clears highest only
        pulse_ext(6);
        do_ack(8'h0E, 1);
        pulse_ext(1);
        chk_int("R5 higher preempts", 1'b1);
        do_ack(8'h09, 1);
        io_write(10'h020, 8'h0B);
        io_read(10'h020, rd); chk("R5 nested in-service", rd, 8'h42);
        io_write(10'h020, 8'h20);
        io_read(10'h020, rd); chk("R8 highest cleared only", rd, 8'h40);
        io_write(10'h020, 8'h20);

        // R9 fixed wiring and ignored lines
        @(negedge clk); timer0_irq = 1'b1;
        @(negedge clk); timer0_irq = 1'b0;
        settle();
        do_ack(8'h08, 1);
        io_write(10'h020, 8'h20);
        pulse_ext(0); pulse_ext(2); pulse_ext(8); pulse_ext(13);
        chk_int("R9 ignored lines no int", 1'b0);
        io_write(10'h020, 8'h0A);
        io_read(10'h020, rd); chk("R9 master pending empty", rd, 8'h00);
        io_read(10'h0A0, rd); chk("R9 slave pending empty", rd, 8'h00);

        // R7 cascade through master input 2
        pulse_ext(10);
        chk_int("R7 slave request reaches cpu", 1'b1);
        do_ack(8'h72, 1);
        io_write(10'h020, 8'h0B);
        io_write(10'h0A0, 8'h0B);
        io_read(10'h020, rd); chk("R7 master bit2 in service", rd, 8'h04);
        io_read(10'h0A0, rd); chk("R7 slave bit in service", rd, 8'h04);
        pulse_ext(1);
        chk_int("R7 master input1 beats cascade slot", 1'b1);
        do_ack(8'h09, 1);
        io_write(10'h020, 8'h20);
        io_read(10'h020, rd); chk("R8 master EOI clears bit1", rd, 8'h04);
        io_write(10'h0A0, 8'h20);
        io_read(10'h0A0, rd); chk("R8 slave EOI", rd, 8'h00);
        io_read(10'h020, rd); chk("R8 master bit2 kept after slave EOI", rd, 8'h04);
        io_write(10'h020, 8'h20);
        io_read(10'h020, rd); chk("R8 master EOI clears bit2", rd, 8'h00);

        // R9 real-time clock on slave input 0
        @(negedge clk); rtc_irq = 1'b1;
        @(negedge clk); rtc_irq = 1'b0;
        settle();
        do_ack(8'h70, 1);
        io_write(10'h0A0, 8'h20);
        io_write(10'h020, 8'h20);

        // R10 init sequence loads base, not mask
        io_write(10'h020, 8'h11);
        io_write(10'h021, 8'h20);
        io_read(10'h021, rd); chk("R10 mask unchanged by base load", rd, 8'h00);
        pulse_ext(7);
        do_ack(8'h27, 1);
        io_write(10'h020, 8'h20);

        // R13 spurious acknowledge
        chk_int("R13 nothing pending", 1'b0);
        do_ack(8'h27, 0);
        io_write(10'h020, 8'h0B);
        io_read(10'h020, rd); chk("R13 no in-service change", rd, 8'h00);
        chk("R12 R13 activity count", 8'(pm_cnt), 8'(pm_exp));
        chk("R6 scoreboard drained", 8'(exp_q.size()), 8'h00);
        finish_run();
    end
endmodule